// File: doc/BRIEF.md
# Open-Page DRAM Command Sequencer

The sequencer takes one memory request at a time from a request queue (read or write, with bank, row and column) and emits the shortest legal series of DRAM commands for it. For each bank it records whether a row is open and which row that is. It sorts each request into one of three classes. A request to the open row is a row hit and needs only a column command. A request to a bank with no open row needs an activate and then a column command. A request to a bank holding another row is a conflict and needs a precharge, an activate and a column command. The gaps between these commands are counted in clock cycles.

At most one command goes out per cycle. When the column command is issued, a one-cycle response pulse reports the class of the request. The request port is ready again in that same cycle. This lets a stream of row hits reach the bus as one column command per cycle, which is page mode. A bank that has just received a read column command cannot be precharged until its read data has come back, which takes a parameterised number of cycles. Writes do not hold the bank.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset no bank has an open row, `cmd_valid_o` is 0, `cmd_o` is 0 (NOP), `rsp_valid_o` is 0 and `req_ready_o` is 1. The first request to each bank is therefore classed as an idle bank.
- R2: If a request is accepted at a clock edge and its row is already open in its bank, only a column command follows, in the next cycle, with class code 0 (hit).
- R3: A request to a bank with no open row issues an activate in the cycle after acceptance. The column command follows T_RCD cycles after the activate. The class code is 1 (idle).
- R4: A request to a bank holding a different open row issues a precharge. The activate follows T_RP cycles after the precharge and the column command follows T_RCD cycles after the activate. The class code is 2 (conflict).
- R5: A precharge to a bank is issued no earlier than CAS_LAT cycles after a read column command to that bank, and otherwise in the cycle after acceptance. A write column command does not delay a later precharge.
- R6: `req_ready_o` is 1 in the cycle a column command is issued, so a request accepted then can be a hit whose column command comes in the very next cycle. This gives back-to-back column commands to one open row.
- R7: `rsp_valid_o` is high for exactly the cycle of each column command, and `rsp_kind_o` carries the class code in that cycle.
- R8: Each bank keeps its own open row. Opening a row in one bank leaves the open row of the other bank unchanged.
- R9: The command codes on `cmd_o` are 0 NOP, 1 precharge, 2 activate, 3 read and 4 write. `cmd_bank_o` names the bank. `cmd_addr_o` holds the row on an activate, the column on a read or write, and 0 on a precharge. At most one command is issued per cycle.
- R10: `req_ready_o` is 0 in every cycle in which a precharge or an activate is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at the edge when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| cmd_valid_o | output | 1 | A command is issued this cycle |
| cmd_o | output | 3 | Command code (R9) |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ADDR_W | Row or column address of the command |
| rsp_valid_o | output | 1 | One-cycle pulse with the column command |
| rsp_kind_o | output | 2 | Class code: 0 hit, 1 idle, 2 conflict |

## Verification
Two functions can fall in the same cycle: issuing a column command and accepting the next request. The second request may also target the same bank as a conflict right after a read, so the read-data hold and the new classification meet at one edge. The bench provokes this by raising the next request while the column command is on the bus. It does this with random pairs and with directed hit-after-hit, conflict-after-read and conflict-after-write pairs. A reference model, driven only by the acceptance cycle, gives the exact cycle of every command, and the bench compares the logged bus against it.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_IDLE     = 2'd1,
    KIND_CONFLICT = 2'd2
  } kind_e;
endpackage

// File: rtl/dram_bank_state.sv
module dram_bank_state #(
  parameter int ROW_W   = 12,
  parameter int CAS_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pre_i,
  input  logic             act_i,
  input  logic             cas_i,
  input  logic             rd_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(CAS_LAT + 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= 1'b0;
      row_q    <= '0;
      rd_cnt_q <= '0;
    end else begin
      if (pre_i) open_q <= 1'b0;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end
      // read data still in flight holds the row
      if (cas_i && rd_i)        rd_cnt_q <= CNT_W'(CAS_LAT - 1);
      else if (rd_cnt_q != '0)  rd_cnt_q <= rd_cnt_q - 1'b1;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign busy_o = (rd_cnt_q != '0);

  a_r5_pre_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (rd_cnt_q == '0));
  a_r4_pre_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q);
  a_r3_act_needs_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q);
  a_r2_cas_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_i |-> open_q);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic                             req_write_i,
  input  logic [BANK_W-1:0]                req_bank_i,
  input  logic [ROW_W-1:0]                 req_row_i,
  input  logic [COL_W-1:0]                 req_col_i,
  input  logic [NUM_BANKS-1:0]             open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  rows_i,
  input  logic [NUM_BANKS-1:0]             busy_i,
  output logic                             pre_go_o,
  output logic                             act_go_o,
  output logic                             cas_go_o,
  output logic [BANK_W-1:0]                bank_o,
  output logic [ROW_W-1:0]                 row_o,
  output logic [COL_W-1:0]                 col_o,
  output logic                             write_o,
  output kind_e                            kind_o
);
  localparam int GAP_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_CAS} st_e;

  st_e              st_q;
  logic [GAP_W-1:0] gap_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  kind_e            kind_q;
  kind_e            new_kind;
  logic             accept;

  always_comb begin
    if (!open_i[req_bank_i])                 new_kind = KIND_IDLE;
    else if (rows_i[req_bank_i] == req_row_i) new_kind = KIND_HIT;
    else                                     new_kind = KIND_CONFLICT;
  end

  assign pre_go_o    = (st_q == S_PRE) && !busy_i[bank_q];
  assign act_go_o    = (st_q == S_ACT) && (gap_q == '0) && !busy_i[bank_q];
  assign cas_go_o    = (st_q == S_CAS) && (gap_q == '0);
  assign req_ready_o = (st_q == S_IDLE) || cas_go_o;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      gap_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      kind_q <= KIND_HIT;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (accept) begin
        bank_q <= req_bank_i;
        row_q  <= req_row_i;
        col_q  <= req_col_i;
        wr_q   <= req_write_i;
        kind_q <= new_kind;
        gap_q  <= '0;
        case (new_kind)
          KIND_HIT:  st_q <= S_CAS;
          KIND_IDLE: st_q <= S_ACT;
          default:   st_q <= S_PRE;
        endcase
      end else if (cas_go_o) begin
        st_q <= S_IDLE;
      end else if (pre_go_o) begin
        st_q  <= S_ACT;
        gap_q <= GAP_W'(T_RP - 1);
      end else if (act_go_o) begin
        st_q  <= S_CAS;
        gap_q <= GAP_W'(T_RCD - 1);
      end
    end
  end

  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign write_o = wr_q;
  assign kind_o  = kind_q;

  // gap checkers, independent of the wait counter
  logic [GAP_W-1:0] since_pre_q, since_act_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre_q <= '0;
      since_act_q <= '0;
    end else begin
      if (pre_go_o)                       since_pre_q <= GAP_W'(1);
      else if (since_pre_q != GAP_W'(GAP_MAX)) since_pre_q <= since_pre_q + 1'b1;
      if (act_go_o)                       since_act_q <= GAP_W'(1);
      else if (since_act_q != GAP_W'(GAP_MAX)) since_act_q <= since_act_q + 1'b1;
    end
  end

  a_r4_act_after_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_go_o && kind_q == KIND_CONFLICT) |-> (since_pre_q >= GAP_W'(T_RP)));
  a_r3_cas_after_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_go_o && kind_q != KIND_HIT) |-> (since_act_q >= GAP_W'(T_RCD)));
  a_r10_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_go_o || act_go_o) |-> !req_ready_o);
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_kind_o
);
  logic [NUM_BANKS-1:0]            open_v, busy_v;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows_v;
  logic                            pre_go, act_go, cas_go, wr_sel;
  logic [BANK_W-1:0]               bank_sel;
  logic [ROW_W-1:0]                row_sel;
  logic [COL_W-1:0]                col_sel;
  kind_e                           kind_sel;
  cmd_e                            cmd;

  dram_seq_fsm #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RP(T_RP), .T_RCD(T_RCD)
  ) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i,
    .req_bank_i, .req_row_i, .req_col_i,
    .open_i(open_v), .rows_i(rows_v), .busy_i(busy_v),
    .pre_go_o(pre_go), .act_go_o(act_go), .cas_go_o(cas_go),
    .bank_o(bank_sel), .row_o(row_sel), .col_o(col_sel),
    .write_o(wr_sel), .kind_o(kind_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_b;
    assign hit_b = (bank_sel == BANK_W'(b));
    dram_bank_state #(.ROW_W(ROW_W), .CAS_LAT(CAS_LAT)) u_state (
      .clk_i, .rst_ni,
      .pre_i (pre_go && hit_b),
      .act_i (act_go && hit_b),
      .cas_i (cas_go && hit_b),
      .rd_i  (!wr_sel),
      .row_i (row_sel),
      .open_o(open_v[b]),
      .row_o (rows_v[b]),
      .busy_o(busy_v[b])
    );
  end

  always_comb begin
    cmd        = CMD_NOP;
    cmd_addr_o = '0;
    if (pre_go) begin
      cmd = CMD_PRE;
    end else if (act_go) begin
      cmd        = CMD_ACT;
      cmd_addr_o = ADDR_W'(row_sel);
    end else if (cas_go) begin
      cmd        = wr_sel ? CMD_WR : CMD_RD;
      cmd_addr_o = ADDR_W'(col_sel);
    end
  end

  assign cmd_o       = cmd;
  assign cmd_valid_o = (cmd != CMD_NOP);
  assign cmd_bank_o  = bank_sel;
  assign rsp_valid_o = cas_go;
  assign rsp_kind_o  = cas_go ? kind_sel : KIND_HIT;

  a_r9_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pre_go, act_go, cas_go}));
  a_r7_rsp_with_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (cmd_o == CMD_RD || cmd_o == CMD_WR));
  a_r8_other_bank_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_go && bank_sel != '0) |=> (open_v[0] == $past(open_v[0])));
endmodule

// File: tb/dram_cmd_seq_test.sv
`timescale 1ns/1ps
module dram_cmd_seq_test;
  localparam int NB = 2, RW = 12, CW = 10, TRP = 2, TRCD = 2, CL = 3;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [0:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic req_ready, cmd_valid, rsp_valid;
  logic [2:0] cmd;
  logic [0:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [1:0] rsp_kind;

  always #4 clk = ~clk;

  dram_cmd_seq #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .T_RP(TRP),
                 .T_RCD(TRCD), .CAS_LAT(CL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr), .rsp_valid_o(rsp_valid),
    .rsp_kind_o(rsp_kind));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // command log, sampled at negedge
  int lcmd[4096], lcyc[4096], lbank[4096], laddr[4096], lrsp[4096], lkind[4096], lrdy[4096];
  int nlog = 0, rptr = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && cmd_valid && nlog < 4096) begin
    lcmd[nlog] = cmd; lcyc[nlog] = cyc; lbank[nlog] = cmd_bank;
    laddr[nlog] = cmd_addr; lrsp[nlog] = rsp_valid; lkind[nlog] = rsp_kind;
    lrdy[nlog] = req_ready; nlog++;
  end

  // reference model
  bit m_open[NB];
  int m_row[NB];
  int m_lastrd[NB];
  int last_cas;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_kind(int b, int r);
    if (!m_open[b]) return 1;
    return (m_row[b] == r) ? 0 : 2;
  endfunction

  task automatic check_seq(int b, int r, int c, bit w, int tacc);
    int k, nexp, pre_t, act_t, cas_t, g;
    int ec[3], et[3], ea[3];
    k = exp_kind(b, r);
    pre_t = tacc + 1;
    if (m_lastrd[b] + CL > pre_t) pre_t = m_lastrd[b] + CL;
    if (k == 0) begin
      nexp = 1; cas_t = tacc + 1;
    end else if (k == 1) begin
      nexp = 2; act_t = tacc + 1; cas_t = act_t + TRCD;
      ec[0] = 2; et[0] = act_t; ea[0] = r;
    end else begin
      nexp = 3; act_t = pre_t + TRP; cas_t = act_t + TRCD;
      ec[0] = 1; et[0] = pre_t; ea[0] = 0;
      ec[1] = 2; et[1] = act_t; ea[1] = r;
    end
    ec[nexp-1] = w ? 4 : 3; et[nexp-1] = cas_t; ea[nexp-1] = c;
    g = 0;
    while (nlog < rptr + nexp && g < 100) begin @(negedge clk); #1; g++; end
    for (int i = 0; i < nexp; i++) begin
      string rq;
      rq = (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
      if (i == 0 && k == 2 && pre_t > tacc + 1) rq = "R5";
      chk(lcmd[rptr+i] == ec[i], rq, "command code", lcmd[rptr+i], ec[i]);
      chk(lcyc[rptr+i] == et[i], rq, "command cycle", lcyc[rptr+i], et[i]);
      chk(lbank[rptr+i] == b && laddr[rptr+i] == ea[i], "R9", "bank/address",
          lbank[rptr+i]*65536 + laddr[rptr+i], b*65536 + ea[i]);
      if (i < nexp - 1) chk(lrdy[rptr+i] == 0, "R10", "ready during PRE/ACT", lrdy[rptr+i], 0);
    end
    chk(lrsp[rptr+nexp-1] == 1 && lkind[rptr+nexp-1] == k, "R7", "response kind",
        lrsp[rptr+nexp-1]*4 + lkind[rptr+nexp-1], 4 + k);
    rptr += nexp;
    m_open[b] = 1; m_row[b] = r;
    if (!w) m_lastrd[b] = cas_t;
    last_cas = cas_t;
  endtask

  task automatic drive(int b, int r, int c, bit w);
    req_valid = 1; req_bank = b[0:0]; req_row = RW'(r); req_col = CW'(c); req_write = w;
  endtask

  task automatic do_req(int b, int r, int c, bit w);
    int tacc;
    @(negedge clk); drive(b, r, c, w);
    while (!req_ready) @(negedge clk);
    tacc = cyc;
    @(negedge clk); req_valid = 0;
    check_seq(b, r, c, w, tacc);
  endtask

  // second request raised while the first one's column command is on the bus
  task automatic do_pair(int b1, int r1, int c1, bit w1, int b2, int r2, int c2, bit w2);
    int t1, t2, cas1;
    @(negedge clk); drive(b1, r1, c1, w1);
    while (!req_ready) @(negedge clk);
    t1 = cyc;
    @(negedge clk); drive(b2, r2, c2, w2);
    while (!req_ready) @(negedge clk);
    t2 = cyc;
    @(negedge clk); req_valid = 0;
    check_seq(b1, r1, c1, w1, t1);
    cas1 = last_cas;
    chk(t2 == cas1, "R6", "accept in CAS cycle", t2, cas1);
    check_seq(b2, r2, c2, w2, t2);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; m_lastrd[i] = -100; end
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && cmd == 0 && rsp_valid == 0, "R1", "idle bus in reset",
        cmd_valid*8 + cmd, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && cmd_valid == 0, "R1", "ready after reset", req_ready*2 + cmd_valid, 2);
    // R1/R3: first touches of each bank are idle-bank sequences
    do_req(0, 1, 5, 0);
    do_req(1, 2, 6, 1);
    // R8: bank 0 row kept after bank 1 activity
    do_req(0, 1, 7, 0);
    chk(lkind[rptr-1] == 0, "R8", "bank 0 still open", lkind[rptr-1], 0);
    // R6: back-to-back hits
    do_pair(0, 1, 8, 0, 0, 1, 9, 1);
    chk(lcyc[rptr-1] == lcyc[rptr-2] + 1, "R6", "CAS gap", lcyc[rptr-1] - lcyc[rptr-2], 1);
    // R5: read then immediate conflict in the same bank, then write then conflict
    do_pair(1, 2, 3, 0, 1, 9, 4, 0);
    do_pair(1, 9, 3, 1, 1, 4, 4, 1);
    // R4 with no pending read
    do_req(0, 3, 11, 1);
    // random mix, fixed seed
    void'($urandom(32'h5eed1));
    for (int n = 0; n < 300; n++) begin
      int b, r, c; bit w;
      b = $urandom_range(0, 1); r = $urandom_range(0, 3);
      c = $urandom_range(0, 1023); w = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0)
        do_pair(b, r, c, w, $urandom_range(0, 1), $urandom_range(0, 3),
                $urandom_range(0, 1023), $urandom_range(0, 1));
      else
        do_req(b, r, c, w);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk(nlog == rptr, "R9", "no stray commands", nlog, rptr);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule